// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port

This block controls eight general-purpose pins. It holds a byte-wide data register and a sixteen-bit mode register, with two mode bits for each pin. Both registers sit on a simple single-cycle register bus. The bus writes on a strobe and reads back through a combinational path. Each pin's mode selects one of four uses:

- the pin is handed to an alternate on-chip function;
- the pin is driven from its data bit;
- the pin is an input with its pull-up on;
- the pin is an input with no pull-up.

For each pin the block exports the output value, the output enable and the pull-up enable to the pad ring. It receives the raw pad level back.

A read of the data register is mode-dependent, bit by bit. A pin set as an input returns its synchronized pad level. A pin set as an output or as an alternate function returns the stored bit. Writes to the data register land in storage in every mode, but the value reaches the pad only in output mode. Two reset inputs exist, and each is asserted asynchronously and released synchronously. Power-on reset clears everything. Manual reset returns all pins to the alternate function but leaves the stored data intact.

Top module: `gpio_port8`

## Requirements
- R1: A bus write to address 0 stores wdata[7:0] in the data register in every pin mode, and bit n belongs to pin n; the stored bit is visible at the pad in output mode.
- R2: Mode field n is mode register bits [2n+1:2n] with code 01 meaning general output: pin_oe[n] is 1 and pin_out[n] equals data bit n, and a read of address 0 returns the stored bit n.
- R3: In mode codes 10 and 11, pin_oe[n] and pin_out[n] are 0 and a read of address 0 returns the pad level of pin_in[n] as seen through two flops, i.e. a pad change is visible after the second rising clock edge.
- R4: In mode code 00, pin_out[n] and pin_oe[n] follow alt_out[n] and alt_oe[n], and a read of address 0 returns the stored bit n.
- R5: pin_pu[n] is 1 exactly when the mode code is 10, and never together with pin_oe[n].
- R6: A data write made while a pin is in an input mode does not change pin_out or pin_oe for that pin.
- R7: While por_n is low and for the first cycles after its release, the data register and the mode register are 0 (all pins in alternate function).
- R8: A manual reset (mrst_n low) clears the mode register to 0 and keeps the data register contents.
- R9: Address 1 holds the mode register (read as rdata[15:0]); address 0 reads as {8'h00, data}; other addresses read 0 and writes to them change nothing.
- R10: The data register changes only on a write to address 0 or on power-on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| mrst_n | input | 1 | Manual reset, active low, clears modes only |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 data, 1 mode) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| pin_in | input | 8 | Raw pad levels |
| alt_out | input | 8 | Alternate function output values |
| alt_oe | input | 8 | Alternate function output enables |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
The bench targets the read-path split. A design that returned the stored bit for input pins, or the pad level for alternate-function pins, would read back the wrong byte when modes are mixed. It also writes data while pins are inputs and then switches them to output. A design that dropped those writes, or drove them early, would show the wrong pad value. The two-flop latency is probed edge by edge, which exposes a missing or extra stage. Separate manual and power-on reset pulses catch a manual reset that wipes data, and a power-on reset that leaves it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_ALT      = 2'b00,
    PM_OUT      = 2'b01,
    PM_IN_PU    = 2'b10,
    PM_IN_FLOAT = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_n = shift_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned ADDR_DATA = 0,
  parameter int unsigned ADDR_MODE = 1,
  localparam int unsigned MREG_W   = 2 * NPINS
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              mode_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MREG_W-1:0] wdata,
  output logic [NPINS-1:0]  data_q,
  output logic [MREG_W-1:0] mode_q
);
  logic              data_en;
  logic              mode_en;
  logic [NPINS-1:0]  data_d;
  logic [MREG_W-1:0] mode_d;

  always_comb begin
    data_en = wr_en && (addr == ADDR_W'(ADDR_DATA));
    mode_en = wr_en && (addr == ADDR_W'(ADDR_MODE));
    data_d  = wdata[NPINS-1:0];
    mode_d  = wdata;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)   data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge mode_rst_n) begin
    if (!mode_rst_n)  mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_port_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              data_bit,
  input  logic              pad_sync,
  input  logic              alt_o,
  input  logic              alt_en,
  output logic              pad_o,
  output logic              pad_oe,
  output logic              pad_pu,
  output logic              rd_bit
);
  pin_mode_e sel;

  always_comb begin
    sel    = pin_mode_e'(mode);
    pad_o  = 1'b0;
    pad_oe = 1'b0;
    pad_pu = 1'b0;
    rd_bit = data_bit;
    unique case (sel)
      PM_ALT: begin
        pad_o  = alt_o;
        pad_oe = alt_en;
      end
      PM_OUT: begin
        pad_o  = data_bit;
        pad_oe = 1'b1;
      end
      PM_IN_PU: begin
        pad_pu = 1'b1;
        rd_bit = pad_sync;
      end
      PM_IN_FLOAT: begin
        rd_bit = pad_sync;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned ADDR_DATA   = 0,
  parameter int unsigned ADDR_MODE   = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  localparam int unsigned MREG_W     = MODE_W * NPINS
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MREG_W-1:0] wdata,
  output logic [MREG_W-1:0] rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_pu
);
  logic              por_rst_n;
  logic              man_rst_n;
  logic              mode_rst_n;
  logic [NPINS-1:0]  pad_sync;
  logic [NPINS-1:0]  data_q;
  logic [MREG_W-1:0] mode_q;
  logic [NPINS-1:0]  rd_vec;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .rst_n(por_rst_n)
  );

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_man_sync (
    .clk(clk), .arst_n(mrst_n), .rst_n(man_rst_n)
  );

  assign mode_rst_n = por_rst_n & man_rst_n;

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(por_rst_n), .d(pin_in), .q(pad_sync)
  );

  gpio_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .ADDR_DATA(ADDR_DATA), .ADDR_MODE(ADDR_MODE)
  ) u_regs (
    .clk(clk), .por_rst_n(por_rst_n), .mode_rst_n(mode_rst_n),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .data_q(data_q), .mode_q(mode_q)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_pin_cell u_cell (
      .mode    (mode_q[MODE_W*g +: MODE_W]),
      .data_bit(data_q[g]),
      .pad_sync(pad_sync[g]),
      .alt_o   (alt_out[g]),
      .alt_en  (alt_oe[g]),
      .pad_o   (pin_out[g]),
      .pad_oe  (pin_oe[g]),
      .pad_pu  (pin_pu[g]),
      .rd_bit  (rd_vec[g])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_DATA))      rdata = {{(MREG_W-NPINS){1'b0}}, rd_vec};
    else if (addr == ADDR_W'(ADDR_MODE)) rdata = mode_q;
  end
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned ADDR_DATA = 0,
  parameter int unsigned ADDR_MODE = 1
) (
  input logic                 clk,
  input logic                 por_rst_n,
  input logic                 mode_rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [2*NPINS-1:0]   wdata,
  input logic [NPINS-1:0]     data_q,
  input logic [2*NPINS-1:0]   mode_q,
  input logic [NPINS-1:0]     pin_oe,
  input logic [NPINS-1:0]     pin_pu
);
  logic hit_data, hit_mode;
  assign hit_data = wr_en && (addr == ADDR_W'(ADDR_DATA));
  assign hit_mode = wr_en && (addr == ADDR_W'(ADDR_MODE));

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!por_rst_n)
    hit_data |=> data_q == $past(wdata[NPINS-1:0])); // R1

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!por_rst_n)
    !hit_data |=> $stable(data_q)); // R10

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!mode_rst_n)
    hit_mode |=> mode_q == $past(wdata)); // R9

  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!mode_rst_n)
    (wr_en && !hit_data && !hit_mode) |=> ($stable(mode_q) && $stable(data_q))); // R9

  AST_PU_NO_DRIVE: assert property (@(posedge clk) disable iff (!por_rst_n)
    (pin_pu & pin_oe) == '0); // R5
endmodule

bind gpio_port8 gpio_port8_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .ADDR_DATA(ADDR_DATA), .ADDR_MODE(ADDR_MODE)
) u_chk (
  .clk(clk), .por_rst_n(por_rst_n), .mode_rst_n(mode_rst_n),
  .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .data_q(data_q), .mode_q(mode_q), .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio_port8_bench.sv
`timescale 1ns/1ps
module gpio_port8_bench;
  logic        clk = 1'b0;
  logic        por_n, mrst_n, wr_en;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic [7:0]  pin_in, alt_out, alt_oe, pin_out, pin_oe, pin_pu;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port8 u_gpio_port8 (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .alt_out(alt_out),
    .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  function automatic logic [7:0] f_out(logic [15:0] m, logic [7:0] d, logic [7:0] ao);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      r[i] = (m[2*i +: 2] == 2'b00) ? ao[i] : (m[2*i +: 2] == 2'b01) ? d[i] : 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] f_oe(logic [15:0] m, logic [7:0] ae);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      r[i] = (m[2*i +: 2] == 2'b00) ? ae[i] : (m[2*i +: 2] == 2'b01);
    return r;
  endfunction

  function automatic logic [7:0] f_pu(logic [15:0] m);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = (m[2*i +: 2] == 2'b10);
    return r;
  endfunction

  function automatic logic [7:0] f_rd(logic [15:0] m, logic [7:0] d, logic [7:0] p);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = m[2*i+1] ? p[i] : d[i];
    return r;
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [15:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, m;
    logic [7:0]  d;
    process::self().srandom(32'd7741);
    por_n = 1'b0; mrst_n = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    pin_in = '0; alt_out = '0; alt_oe = '0;
    cycles(5);
    por_n = 1'b1;
    cycles(4);
    // R7 reset state
    bus_rd(2'd0, v); check("R7 data after por", v, 16'h0000);
    bus_rd(2'd1, v); check("R7 mode after por", v, 16'h0000);
    check("R7 oe follows alt", {8'h0, pin_oe}, 16'h0000);
    check("R5 no pull-up at reset", {8'h0, pin_pu}, 16'h0000);

    // R2 / R1 output mode
    bus_wr(2'd1, 16'h5555);
    bus_wr(2'd0, 16'h003C);
    check("R2 pin_out", {8'h0, pin_out}, 16'h003C);
    check("R2 pin_oe", {8'h0, pin_oe}, 16'h00FF);
    bus_rd(2'd0, v); check("R2 read stored", v, 16'h003C);

    // R3 / R5 / R6 pull-up inputs
    bus_wr(2'd1, 16'hAAAA);
    pin_in = 8'h96;
    cycles(3);
    check("R5 pull-up all", {8'h0, pin_pu}, 16'h00FF);
    check("R3 oe off", {8'h0, pin_oe}, 16'h0000);
    bus_rd(2'd0, v); check("R3 read pad", v, 16'h0096);
    bus_wr(2'd0, 16'h0011);
    check("R6 pin_out unchanged", {8'h0, pin_out}, 16'h0000);
    check("R6 pin_oe unchanged", {8'h0, pin_oe}, 16'h0000);
    bus_rd(2'd0, v); check("R3 read still pad", v, 16'h0096);
    bus_wr(2'd1, 16'h5555);
    check("R1 stored in input mode", {8'h0, pin_out}, 16'h0011);

    // R3 two-flop latency
    bus_wr(2'd1, 16'hFFFF);
    pin_in = 8'h00;
    cycles(3);
    pin_in = 8'hFF;
    @(negedge clk);
    bus_rd(2'd0, v); check("R3 one edge old level", v, 16'h0000);
    @(negedge clk);
    bus_rd(2'd0, v); check("R3 two edges new level", v, 16'h00FF);
    check("R5 float no pull-up", {8'h0, pin_pu}, 16'h0000);

    // R4 alternate function
    bus_wr(2'd1, 16'h0000);
    alt_out = 8'hA5; alt_oe = 8'h0F;
    #0.5;
    check("R4 pin_out alt", {8'h0, pin_out}, 16'h00A5);
    check("R4 pin_oe alt", {8'h0, pin_oe}, 16'h000F);
    bus_rd(2'd0, v); check("R4 read stored", v, 16'h0011);

    // R9 other addresses
    bus_wr(2'd2, 16'hFFFF);
    bus_wr(2'd3, 16'hFFFF);
    bus_rd(2'd0, v); check("R9 data untouched", v, 16'h0011);
    bus_rd(2'd1, v); check("R9 mode untouched", v, 16'h0000);
    bus_rd(2'd3, v); check("R9 unused reads zero", v, 16'h0000);

    // R8 manual reset
    bus_wr(2'd1, 16'h5555);
    bus_wr(2'd0, 16'h00C3);
    @(negedge clk); mrst_n = 1'b0;
    cycles(2); mrst_n = 1'b1;
    cycles(3);
    bus_rd(2'd1, v); check("R8 mode cleared", v, 16'h0000);
    bus_rd(2'd0, v); check("R8 data kept", v, 16'h00C3);
    check("R8 oe back to alt", {8'h0, pin_oe}, 16'h000F);

    // R7 power-on reset clears data
    @(negedge clk); por_n = 1'b0;
    #0.5;
    bus_rd(2'd0, v); check("R7 data cleared in por", v, 16'h0000);
    cycles(2); por_n = 1'b1;
    cycles(4);
    bus_rd(2'd0, v); check("R7 data after second por", v, 16'h0000);

    // Mixed random modes: R1 R2 R3 R4 R5 R10
    for (int it = 0; it < 300; it++) begin
      m = 16'($urandom); d = 8'($urandom);
      bus_wr(2'd1, m);
      bus_wr(2'd0, {8'($urandom), d});
      pin_in = 8'($urandom); alt_out = 8'($urandom); alt_oe = 8'($urandom);
      cycles(3);
      check("R2 R4 random pin_out", {8'h0, pin_out}, {8'h0, f_out(m, d, alt_out)});
      check("R2 R3 random pin_oe", {8'h0, pin_oe}, {8'h0, f_oe(m, alt_oe)});
      check("R5 random pin_pu", {8'h0, pin_pu}, {8'h0, f_pu(m)});
      bus_rd(2'd0, v); check("R1 R10 random read", v, {8'h0, f_rd(m, d, pin_in)});
      bus_rd(2'd1, v); check("R9 random mode read", v, m);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule